// File: doc/BRIEF.md
# DMA Channel Request Selector

This block produces the transfer request for a single DMA channel. A four-bit source code and a one-bit set select pick one hardware event from a group of timer underflow pulses, serial port transmit and receive events, a conversion-done pulse and an external interrupt pin. When the chosen event fires, a pending flag is set; the flag is forwarded to the transfer engine only while the channel is enabled. An acknowledge pulse from the engine clears the flag.

Two byte-wide registers sit on a simple write-strobe register bus. The control register (address 0) holds the enable, the pending flag and the transfer attributes that the engine consumes. The source register (address 1) holds the source code, the set select and a write-only software trigger. The pending flag can be cleared by software but never set by it; only a selected source can set it. The external pin passes through a two-stage synchroniser before edge detection.

Top module: `dma_req_ctl`

## Requirements
- R1: After reset both registers read 00h and `dma_req` is 0.
- R2: With set select 0, source codes map as: 2..6 = `tmra_uf[0..4]`, 7..9 = `tmrb_uf[0..2]`, 10 = `ser_tx_evt[0]`, 11 = `ser_rx_evt[0]`, 12 = `ser_tx_evt[2]`, 13 = `ser_rx_evt[2]`, 14 = `adc_done`, 15 = `ser_tx_evt[1]`; a one-cycle pulse on the selected input sets the pending flag at the next clock edge, while a pulse on any other input has no effect.
- R3: With set select 0 and code 0, a falling edge of `ext_int_pin` sets the pending flag at the third rising clock edge after the pin changes (two synchroniser stages plus the flag register); a rising edge has no effect.
- R4: With set select 1, code 0 selects `ser3_evt`, code 1 selects both edges of `ext_int_pin` (same three-edge latency), code 2 selects `ser_rx_evt[1]`, and codes 3..15 select the same sources as with set select 0.
- R5: Source register layout: bits 3:0 source code, bit 4 set select, bit 5 software trigger, bits 7:6 unused. Writing 1 to bit 5 sets the pending flag only when the same write holds set select 0 and code 0001; bit 5 and bits 7:6 always read 0.
- R6: Writing 0 to the control register's flag bit clears the pending flag; writing 1 leaves it unchanged, so a clear flag stays clear.
- R7: When a selected source fires in the same cycle as a software clear or an acknowledge, the flag ends set.
- R8: Control register layout: bit 0 enable, bit 1 pending flag, bit 2 transfer unit (1 = 8 bits), bit 3 repeat mode, bit 4 source forward, bit 5 destination forward; bits 7:6 read 0 whatever is written.
- R9: A control write that sets both direction bits to forward leaves both direction bits at their previous values; the other bits of that write still take effect.
- R10: `dma_req` is 1 exactly when the flag and enable are both 1; while enable is 0, sources still set the flag, which appears on `dma_req` once enable is written 1.
- R11: A one-cycle `dma_ack` clears the pending flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ext_int_pin | input | 1 | Asynchronous external interrupt pin |
| tmra_uf | input | 5 | Timer group A underflow pulses |
| tmrb_uf | input | 3 | Timer group B underflow pulses |
| ser_tx_evt | input | 3 | Serial ports 0..2 transmit events |
| ser_rx_evt | input | 3 | Serial ports 0..2 receive events |
| ser3_evt | input | 1 | Serial port 3 event |
| adc_done | input | 1 | Conversion-complete pulse |
| dma_ack | input | 1 | Acknowledge from transfer engine |
| dma_req | output | 1 | Request to transfer engine |
| xfer_unit8 | output | 1 | Transfer unit: 1 = byte, 0 = 16-bit |
| xfer_repeat | output | 1 | Repeat transfer mode |
| src_fwd | output | 1 | Source address moves forward |
| dst_fwd | output | 1 | Destination address moves forward |

## Verification
The hardest situation to reach is a selected source firing in exactly the cycle that software writes a clear, since the two arrive through unrelated paths. The stimulus drives a control write with the flag bit at 0 and the selected timer pulse on the same clock edge, then reads the control register to see the flag survive. The pin paths are exercised by holding the pin level across three edges and checking that the flag stays clear for the first two.

// File: rtl/dma_req_pkg.sv
// Package: shared constants and types for the DMA request selector.
// Assumes an 8-bit register bus with two registers.
package dma_req_pkg;

    localparam int REG_W       = 8;
    localparam int ADDR_W      = 1;
    localparam int CODE_W      = 4;
    localparam int NUM_CODES   = 1 << CODE_W;
    localparam int NUM_TMRA    = 5;
    localparam int NUM_TMRB    = 3;
    localparam int NUM_SER     = 3;
    localparam int SYNC_STAGES = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_CAUSE = 1'b1;

    // control register bit positions
    localparam int CB_EN   = 0;
    localparam int CB_FLAG = 1;
    localparam int CB_U8   = 2;
    localparam int CB_RPT  = 3;
    localparam int CB_SRC  = 4;
    localparam int CB_DST  = 5;

    // source register bit positions
    localparam int SB_EXP = 4;
    localparam int SB_SW  = 5;

    // basic set code assignments
    localparam int C_PIN_FALL = 0;
    localparam int C_SOFT     = 1;
    localparam int C_TMRA0    = 2;
    localparam int C_TMRB0    = C_TMRA0 + NUM_TMRA;
    localparam int C_TX0      = 10;
    localparam int C_RX0      = 11;
    localparam int C_TX2      = 12;
    localparam int C_RX2      = 13;
    localparam int C_ADC      = 14;
    localparam int C_TX1      = 15;

    // extended set overrides
    localparam int X_SER3     = 0;
    localparam int X_PIN_BOTH = 1;
    localparam int X_RX1      = 2;

    localparam logic [CODE_W-1:0] SOFT_CODE = CODE_W'(C_SOFT);

    typedef struct packed {
        logic dst_fwd;
        logic src_fwd;
        logic repeat_mode;
        logic unit8;
        logic req_flag;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/dma_pin_edge.sv
// Module: synchronises the external pin and detects its edges.
// Assumes the pin idles high; the chain resets to 1 so reset never fakes an edge.
module dma_pin_edge #(
    parameter int STAGES = dma_req_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_pulse,
    output logic any_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // shift the pin through the synchroniser and keep the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    // one-cycle pulses from the level change
    always_comb begin
        fall_pulse = last_q & ~sync_q[STAGES-1];
        any_pulse  = last_q ^ sync_q[STAGES-1];
    end

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse); // R3

endmodule

// File: rtl/dma_cause_sel.sv
// Module: picks the hardware event named by the source code and set select.
// Assumes all event inputs are single-cycle pulses in the clk domain.
module dma_cause_sel
    import dma_req_pkg::*;
(
    input  logic [CODE_W-1:0]   code,
    input  logic                ext_set,
    input  logic                pin_fall,
    input  logic                pin_any,
    input  logic [NUM_TMRA-1:0] tmra_uf,
    input  logic [NUM_TMRB-1:0] tmrb_uf,
    input  logic [NUM_SER-1:0]  ser_tx_evt,
    input  logic [NUM_SER-1:0]  ser_rx_evt,
    input  logic                ser3_evt,
    input  logic                adc_done,
    output logic                hw_hit
);
    logic [NUM_CODES-1:0] basic_src;
    logic [NUM_CODES-1:0] ext_src;

    // timer groups occupy consecutive codes
    for (genvar i = 0; i < NUM_TMRA; i++) begin : g_tmra
        assign basic_src[C_TMRA0 + i] = tmra_uf[i];
    end
    for (genvar j = 0; j < NUM_TMRB; j++) begin : g_tmrb
        assign basic_src[C_TMRB0 + j] = tmrb_uf[j];
    end

    // remaining basic sources; the software code has no hardware event
    assign basic_src[C_PIN_FALL] = pin_fall;
    assign basic_src[C_SOFT]     = 1'b0;
    assign basic_src[C_TX0]      = ser_tx_evt[0];
    assign basic_src[C_RX0]      = ser_rx_evt[0];
    assign basic_src[C_TX2]      = ser_tx_evt[2];
    assign basic_src[C_RX2]      = ser_rx_evt[2];
    assign basic_src[C_ADC]      = adc_done;
    assign basic_src[C_TX1]      = ser_tx_evt[1];

    // extended set reuses the basic map except for three codes
    always_comb begin
        ext_src             = basic_src;
        ext_src[X_SER3]     = ser3_evt;
        ext_src[X_PIN_BOTH] = pin_any;
        ext_src[X_RX1]      = ser_rx_evt[1];
    end

    // final selection
    always_comb begin
        hw_hit = ext_set ? ext_src[code] : basic_src[code];
    end

endmodule

// File: rtl/dma_reg_file.sv
// Module: control and source registers plus the pending-request flag.
// Assumes one register write per cycle; reads are combinational.
module dma_reg_file
    import dma_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              hw_hit,
    input  logic              dma_ack,
    output logic [CODE_W-1:0] code,
    output logic              ext_set,
    output ctrl_t             ctrl
);
    ctrl_t             ctrl_q;
    logic [CODE_W-1:0] code_q;
    logic              ext_q;
    logic              wr_ctrl;
    logic              wr_cause;
    logic              sw_trig;
    logic              flag_set;
    logic              flag_clr;
    logic              dir_bad;
    logic              unused_hi;

    // write decode and flag set/clear terms
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
        wr_cause = reg_wr && (reg_addr == ADDR_CAUSE);
        sw_trig  = wr_cause && reg_wdata[SB_SW] && !reg_wdata[SB_EXP]
                   && (reg_wdata[CODE_W-1:0] == SOFT_CODE);
        flag_set = hw_hit || sw_trig;
        flag_clr = dma_ack || (wr_ctrl && !reg_wdata[CB_FLAG]);
        dir_bad  = reg_wdata[CB_SRC] && reg_wdata[CB_DST];
    end

    assign unused_hi = ^reg_wdata[REG_W-1:CB_DST+1];

    // control register: set wins over clear, illegal direction pair refused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (flag_set)
                ctrl_q.req_flag <= 1'b1;
            else if (flag_clr)
                ctrl_q.req_flag <= 1'b0;
            if (wr_ctrl) begin
                ctrl_q.enable      <= reg_wdata[CB_EN];
                ctrl_q.unit8       <= reg_wdata[CB_U8];
                ctrl_q.repeat_mode <= reg_wdata[CB_RPT];
                if (!dir_bad) begin
                    ctrl_q.src_fwd <= reg_wdata[CB_SRC];
                    ctrl_q.dst_fwd <= reg_wdata[CB_DST];
                end
            end
        end
    end

    // source register: code and set select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            ext_q  <= 1'b0;
        end else if (wr_cause) begin
            code_q <= reg_wdata[CODE_W-1:0];
            ext_q  <= reg_wdata[SB_EXP];
        end
    end

    // read mux; trigger and unused bits read as zero
    always_comb begin
        if (reg_addr == ADDR_CTRL)
            reg_rdata = REG_W'(ctrl_q);
        else
            reg_rdata = REG_W'({ext_q, code_q});
    end

    assign code    = code_q;
    assign ext_set = ext_q;
    assign ctrl    = ctrl_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |=> ctrl_q.req_flag); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !hw_hit && !wr_cause) |=> !ctrl_q.req_flag); // R11
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.req_flag && !hw_hit && !wr_cause) |=> !ctrl_q.req_flag); // R6
    AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.src_fwd && ctrl_q.dst_fwd)); // R9

endmodule

// File: rtl/dma_req_ctl.sv
// Module: top of the DMA request selector for one channel.
// Assumes event inputs are clk-domain pulses; only ext_int_pin is asynchronous.
module dma_req_ctl
    import dma_req_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                ext_int_pin,
    input  logic [NUM_TMRA-1:0] tmra_uf,
    input  logic [NUM_TMRB-1:0] tmrb_uf,
    input  logic [NUM_SER-1:0]  ser_tx_evt,
    input  logic [NUM_SER-1:0]  ser_rx_evt,
    input  logic                ser3_evt,
    input  logic                adc_done,
    input  logic                dma_ack,
    output logic                dma_req,
    output logic                xfer_unit8,
    output logic                xfer_repeat,
    output logic                src_fwd,
    output logic                dst_fwd
);
    logic              pin_fall;
    logic              pin_any;
    logic              hw_hit;
    logic [CODE_W-1:0] code;
    logic              ext_set;
    ctrl_t             ctrl;

    dma_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_int_pin),
        .fall_pulse (pin_fall),
        .any_pulse  (pin_any)
    );

    dma_cause_sel u_sel (
        .code       (code),
        .ext_set    (ext_set),
        .pin_fall   (pin_fall),
        .pin_any    (pin_any),
        .tmra_uf    (tmra_uf),
        .tmrb_uf    (tmrb_uf),
        .ser_tx_evt (ser_tx_evt),
        .ser_rx_evt (ser_rx_evt),
        .ser3_evt   (ser3_evt),
        .adc_done   (adc_done),
        .hw_hit     (hw_hit)
    );

    dma_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hw_hit    (hw_hit),
        .dma_ack   (dma_ack),
        .code      (code),
        .ext_set   (ext_set),
        .ctrl      (ctrl)
    );

    // forward the pending flag only while the channel is enabled
    always_comb begin
        dma_req     = ctrl.enable && ctrl.req_flag;
        xfer_unit8  = ctrl.unit8;
        xfer_repeat = ctrl.repeat_mode;
        src_fwd     = ctrl.src_fwd;
        dst_fwd     = ctrl.dst_fwd;
    end

endmodule

// File: tb/dma_req_ctl_test.sv
`timescale 1ns/1ps
module dma_req_ctl_test;
    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [0:0]  reg_addr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        ext_int_pin = 1'b1;
    logic [15:0] evv = '0;
    logic [4:0]  tmra_uf;
    logic [2:0]  tmrb_uf;
    logic [2:0]  ser_tx_evt;
    logic [2:0]  ser_rx_evt;
    logic        ser3_evt;
    logic        adc_done;
    logic        dma_ack = 1'b0;
    logic        dma_req;
    logic        xfer_unit8, xfer_repeat, src_fwd, dst_fwd;

    // event vector index: tmra 0..4, tmrb 5..7, tx 8..10, rx 11..13, adc 14, ser3 15
    assign {ser3_evt, adc_done, ser_rx_evt, ser_tx_evt, tmrb_uf, tmra_uf} = evv;

    always #(CLK_P/2) clk = ~clk;

    dma_req_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_int_pin(ext_int_pin),
        .tmra_uf(tmra_uf), .tmrb_uf(tmrb_uf), .ser_tx_evt(ser_tx_evt),
        .ser_rx_evt(ser_rx_evt), .ser3_evt(ser3_evt), .adc_done(adc_done),
        .dma_ack(dma_ack), .dma_req(dma_req), .xfer_unit8(xfer_unit8),
        .xfer_repeat(xfer_repeat), .src_fwd(src_fwd), .dst_fwd(dst_fwd)
    );

    typedef struct {
        string      tag;
        logic       req;
        logic [7:0] rd;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // monitor: pops one expectation per clock, samples after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (dma_req !== e.req || reg_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s: req=%0b rdata=%02h expected req=%0b rdata=%02h",
                             e.tag, dma_req, reg_rdata, e.req, e.rd);
                end
            end
        end
    end

    // driver helpers: inputs set at negedge, expectation for the next edge queued
    task automatic tick(input string t, input logic er, input logic [7:0] erd);
        exp_t e;
        e.tag = t; e.req = er; e.rd = erd;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wreg(input logic a, input logic [7:0] d, input logic er,
                        input logic [7:0] erd, input string t);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(t, er, erd);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic a, input logic er, input logic [7:0] erd,
                        input string t);
        reg_addr = a;
        tick(t, er, erd);
    endtask

    task automatic pulse(input int idx, input logic er, input logic [7:0] erd,
                         input string t);
        reg_addr = 1'b0; evv[idx] = 1'b1;
        tick(t, er, erd);
        evv[idx] = 1'b0;
    endtask

    task automatic do_ack(input string t);
        reg_addr = 1'b0; dma_ack = 1'b1;
        tick(t, 1'b0, 8'h01);
        dma_ack = 1'b0;
    endtask

    function automatic int code_idx(input int c);
        case (c)
            2, 3, 4, 5, 6: return c - 2;
            7, 8, 9:       return c - 2;
            10:            return 8;
            11:            return 11;
            12:            return 10;
            13:            return 13;
            14:            return 14;
            default:       return 9;
        endcase
    endfunction

    // watchdog
    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rreg(1'b0, 1'b0, 8'h00, "R1 ctrl after reset");
        rreg(1'b1, 1'b0, 8'h00, "R1 source after reset");
        wreg(1'b0, 8'h01, 1'b0, 8'h01, "R8 enable write");
        // R2: selected and unselected sources
        wreg(1'b1, 8'h02, 1'b0, 8'h02, "R2 select code 2");
        pulse(0, 1'b1, 8'h03, "R2 tmra0 sets flag");
        do_ack("R11 ack clears flag");
        pulse(1, 1'b0, 8'h01, "R2 unselected tmra1 ignored");
        for (int c = 2; c < 16; c++) begin
            wreg(1'b1, 8'(c), 1'b0, 8'(c), $sformatf("R2 select code %0d", c));
            pulse(code_idx(c), 1'b1, 8'h03, $sformatf("R2 code %0d hit", c));
            do_ack($sformatf("R11 ack after code %0d", c));
        end
        // R5: software trigger
        wreg(1'b1, 8'h21, 1'b1, 8'h01, "R5 soft trigger, bit reads 0");
        rreg(1'b0, 1'b1, 8'h03, "R5 soft trigger set flag");
        do_ack("R11 ack after soft trigger");
        wreg(1'b1, 8'h22, 1'b0, 8'h02, "R5 trigger with code 2");
        rreg(1'b0, 1'b0, 8'h01, "R5 trigger with code 2 no set");
        wreg(1'b1, 8'h31, 1'b0, 8'h11, "R5 trigger with extended set");
        rreg(1'b0, 1'b0, 8'h01, "R5 trigger with extended set no set");
        // R6: software clear only
        wreg(1'b1, 8'h21, 1'b1, 8'h01, "R6 setup soft set");
        wreg(1'b0, 8'h03, 1'b1, 8'h03, "R6 writing 1 keeps flag");
        wreg(1'b0, 8'h01, 1'b0, 8'h01, "R6 writing 0 clears flag");
        wreg(1'b0, 8'h03, 1'b0, 8'h01, "R6 writing 1 cannot set flag");
        // R7: set beats simultaneous clear
        wreg(1'b1, 8'h02, 1'b0, 8'h02, "R7 select code 2");
        reg_addr = 1'b0; reg_wdata = 8'h01; reg_wr = 1'b1; evv[0] = 1'b1;
        tick("R7 set wins over clear write", 1'b1, 8'h03);
        reg_wr = 1'b0; evv[0] = 1'b0;
        reg_addr = 1'b0; dma_ack = 1'b1; evv[0] = 1'b1;
        tick("R7 set wins over ack", 1'b1, 8'h03);
        dma_ack = 1'b0; evv[0] = 1'b0;
        do_ack("R11 ack after R7");
        // R10: latch while disabled
        wreg(1'b0, 8'h00, 1'b0, 8'h00, "R10 disable");
        pulse(0, 1'b0, 8'h02, "R10 flag latched, no request");
        wreg(1'b0, 8'h03, 1'b1, 8'h03, "R10 enable forwards pending flag");
        do_ack("R11 ack after R10");
        // R9 / R8: direction rule and reserved bits
        wreg(1'b0, 8'h11, 1'b0, 8'h11, "R8 source forward");
        wreg(1'b0, 8'h35, 1'b0, 8'h15, "R9 both forward refused");
        wreg(1'b0, 8'h29, 1'b0, 8'h29, "R8 dest forward and repeat");
        wreg(1'b0, 8'hC1, 1'b0, 8'h01, "R8 reserved bits read 0");
        wreg(1'b1, 8'hE3, 1'b0, 8'h03, "R5 source reserved and trigger bits read 0");
        // R3: falling edge of pin, basic set
        wreg(1'b1, 8'h00, 1'b0, 8'h00, "R3 select pin fall");
        reg_addr = 1'b0;
        ext_int_pin = 1'b0;
        tick("R3 fall edge 1", 1'b0, 8'h01);
        tick("R3 fall edge 2", 1'b0, 8'h01);
        tick("R3 fall edge 3 sets", 1'b1, 8'h03);
        do_ack("R11 ack after pin fall");
        ext_int_pin = 1'b1;
        for (int k = 0; k < 3; k++) tick("R3 rising edge ignored", 1'b0, 8'h01);
        pulse(15, 1'b0, 8'h01, "R4 ser3 ignored in basic set");
        // R4: extended set
        wreg(1'b1, 8'h11, 1'b0, 8'h11, "R4 select both pin edges");
        reg_addr = 1'b0;
        ext_int_pin = 1'b0;
        tick("R4 fall 1", 1'b0, 8'h01);
        tick("R4 fall 2", 1'b0, 8'h01);
        tick("R4 fall 3 sets", 1'b1, 8'h03);
        do_ack("R11 ack after R4 fall");
        ext_int_pin = 1'b1;
        tick("R4 rise 1", 1'b0, 8'h01);
        tick("R4 rise 2", 1'b0, 8'h01);
        tick("R4 rise 3 sets", 1'b1, 8'h03);
        do_ack("R11 ack after R4 rise");
        wreg(1'b1, 8'h10, 1'b0, 8'h10, "R4 select ser3");
        pulse(15, 1'b1, 8'h03, "R4 ser3 hit");
        do_ack("R11 ack after ser3");
        wreg(1'b1, 8'h12, 1'b0, 8'h12, "R4 select ser1 rx");
        pulse(11, 1'b0, 8'h01, "R4 ser0 rx ignored at code 2");
        pulse(12, 1'b1, 8'h03, "R4 ser1 rx hit");
        do_ack("R11 ack after ser1 rx");
        wreg(1'b1, 8'h15, 1'b0, 8'h15, "R4 extended code 5");
        pulse(3, 1'b1, 8'h03, "R4 extended code 5 uses tmra3");
        do_ack("R11 ack after extended code 5");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule